// File: doc/BRIEF.md
# HDLC Interrupt Status Capture

This block is the interrupt status register of an HDLC link controller. It latches eight event indications from the receiver, the transmitter and the FIFO level monitors into one 8-bit register. It combines that register with an 8-bit enable mask to drive a single active-high interrupt line. A bit records that its event happened. It does not report whether the condition still holds, so software polls the live status elsewhere.

A microprocessor read of the register's address returns the latched bits and clears the whole register, which also drops the interrupt. An event that arrives during a read is held back while the read lasts. It is posted once the read ends, unless its bit was already set when it arrived. Mode inputs move the FIFO level thresholds and select which event bit 2 reports.

Top module: `hdlc_isr`

## Requirements
- R1: After reset, every status bit reads 0 and `irq_o` is 0.
- R2: Bit positions: 7 go-ahead detected (`ga_det_i`), 6 end-of-packet byte written to the Rx FIFO (`eop_wr_i`), 5 transmit packet finished or aborted (`tx_done_i`), 4 last byte of a packet next to read (`eop_rd_i`), 0 write attempt (`rx_wr_i`) while the Rx count equals the FIFO depth. A one-cycle pulse sets its bit one clock later, and the bit stays set.
- R3: A read with `rd_stb_i` high and `rd_addr_i` equal to 7 shows the status on `rd_data_o`. When the strobe falls, all bits clear.
- R4: `irq_o` is high exactly when some status bit and its `irq_en_i` bit are both 1. It changes on the same clock edge as the status.
- R5: Bit 3 sets when the Tx count moves from 5 to 4, or from 15 to 14 when `fltx_i` is 1. No other move of the count sets it.
- R6: Bit 1 sets when the Rx count moves from 14 to 15, or from 4 to 5 when `flrx_i` is 1. No other move of the count sets it.
- R7: With `intsel_i` 0, bit 2 sets on `rx_abort_i` only if at least 26 `rx_bit_i` strobes came since the last `rx_flag_i` or abort. Earlier aborts are ignored.
- R8: With `intsel_i` 1, bit 2 sets on `tx_rd_i` when the Tx count is 0 and `tx_last_tag_i` is 0. Aborts do not set it.
- R9: An event during a read leaves the data returned by that read unchanged. Its bit is set after the read ends.
- R10: An event during a read whose bit is already set is dropped, so the bit is 0 after the read ends.
- R11: A strobe at any address other than 7 returns 0 on `rd_data_o` and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ga_det_i | input | 1 | Go-ahead pattern detected pulse |
| eop_wr_i | input | 1 | End-of-packet byte written to Rx FIFO pulse |
| tx_done_i | input | 1 | Closing flag sent or packet aborted pulse |
| eop_rd_i | input | 1 | Next Rx byte to read ends a packet pulse |
| rx_wr_i | input | 1 | Rx FIFO write attempt |
| rx_count_i | input | 5 | Rx FIFO occupancy |
| tx_count_i | input | 5 | Tx FIFO occupancy |
| tx_rd_i | input | 1 | Transmitter read attempt from Tx FIFO |
| tx_last_tag_i | input | 1 | Last Tx byte was tagged end or abort |
| rx_flag_i | input | 1 | Receiver saw a flag (packet start) |
| rx_bit_i | input | 1 | One packet bit received |
| rx_abort_i | input | 1 | Abort sequence received |
| fltx_i | input | 1 | Tx threshold select |
| flrx_i | input | 1 | Rx threshold select |
| intsel_i | input | 1 | Bit 2 source select |
| irq_en_i | input | 8 | Interrupt enable mask |
| rd_stb_i | input | 1 | Bus read strobe |
| rd_addr_i | input | 4 | Bus address |
| rd_data_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench aims at the read window. If an event posted during a read changed the data returned, the read would lose data. If it vanished, an event would be lost. If it came back after hitting a bit that was already set, software would see a duplicate interrupt. It walks each FIFO count through the threshold in both directions and under both mode settings. A detector that fired on a level instead of a move would keep setting the bit, and one that ignored direction would fire on refill. It also sends aborts 25 and 26 bits into a packet, where an off-by-one counter shows up as a wrong bit 2.

// File: rtl/hdlc_isr_pkg.sv
package hdlc_isr_pkg;
   localparam int unsigned ISR_W   = 8;
   localparam int unsigned B_GA    = 7;
   localparam int unsigned B_EOPW  = 6;
   localparam int unsigned B_TXEND = 5;
   localparam int unsigned B_EOPR  = 4;
   localparam int unsigned B_TXLOW = 3;
   localparam int unsigned B_ABUND = 2;
   localparam int unsigned B_RXHI  = 1;
   localparam int unsigned B_RXOV  = 0;
   typedef logic [ISR_W-1:0] isr_t;
endpackage

// File: rtl/isr_level_cross.sv
module isr_level_cross #(
   parameter int unsigned CNT_W    = 5,
   parameter int unsigned NRM_FROM = 5,
   parameter int unsigned NRM_TO   = 4,
   parameter int unsigned ALT_FROM = 15,
   parameter int unsigned ALT_TO   = 14
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             alt_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             cross_o
);
   localparam logic [CNT_W-1:0] NF = CNT_W'(NRM_FROM);
   localparam logic [CNT_W-1:0] NT = CNT_W'(NRM_TO);
   localparam logic [CNT_W-1:0] AF = CNT_W'(ALT_FROM);
   localparam logic [CNT_W-1:0] AT = CNT_W'(ALT_TO);

   logic [CNT_W-1:0] prev_q;
   logic [CNT_W-1:0] from_w, to_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= count_i;
   end

   always_comb begin
      from_w  = alt_i ? AF : NF;
      to_w    = alt_i ? AT : NT;
      cross_o = (prev_q == from_w) && (count_i == to_w);
   end
endmodule

// File: rtl/isr_abort_qual.sv
module isr_abort_qual #(
   parameter int unsigned MIN_BITS = 26
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic flag_i,
   input  logic bit_i,
   input  logic abort_i,
   output logic valid_o
);
   localparam int unsigned CW = $clog2(MIN_BITS + 1);
   localparam logic [CW-1:0] SAT = CW'(MIN_BITS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (flag_i || abort_i) cnt_q <= '0;
      else if (bit_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
   end

   assign valid_o = abort_i && (cnt_q == SAT);
endmodule

// File: rtl/isr_capture_bit.sv
module isr_capture_bit (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rd_now_i,
   input  logic rd_end_i,
   input  logic ev_i,
   output logic stat_o,
   output logic stat_nxt_o
);
   logic stat_q, hold_q, hold_nxt;

   always_comb begin
      stat_nxt_o = stat_q;
      hold_nxt   = hold_q;
      if (rd_end_i) begin
         stat_nxt_o = hold_q | ev_i;
         hold_nxt   = 1'b0;
      end else if (rd_now_i) begin
         if (ev_i && !stat_q) hold_nxt = 1'b1;
      end else if (ev_i) begin
         stat_nxt_o = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         stat_q <= stat_nxt_o;
         hold_q <= hold_nxt;
      end
   end

   assign stat_o = stat_q;
endmodule

// File: rtl/hdlc_isr.sv
module hdlc_isr
   import hdlc_isr_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH   = 16,
   parameter int unsigned CNT_W        = $clog2(FIFO_DEPTH + 1),
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned ISR_ADDR     = 7,
   parameter int unsigned ABORT_MIN    = 26,
   parameter int unsigned TX_LOW_NRM   = 5,
   parameter int unsigned TX_LOW_ALT   = 15,
   parameter int unsigned RX_HIGH_NRM  = 14,
   parameter int unsigned RX_HIGH_ALT  = 4,
   parameter bit          IRQ_REG      = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ga_det_i,
   input  logic              eop_wr_i,
   input  logic              tx_done_i,
   input  logic              eop_rd_i,
   input  logic              rx_wr_i,
   input  logic [CNT_W-1:0]  rx_count_i,
   input  logic [CNT_W-1:0]  tx_count_i,
   input  logic              tx_rd_i,
   input  logic              tx_last_tag_i,
   input  logic              rx_flag_i,
   input  logic              rx_bit_i,
   input  logic              rx_abort_i,
   input  logic              fltx_i,
   input  logic              flrx_i,
   input  logic              intsel_i,
   input  logic [ISR_W-1:0]  irq_en_i,
   input  logic              rd_stb_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [ISR_W-1:0]  rd_data_o,
   output logic              irq_o
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ISR_ADDR);
   localparam logic [CNT_W-1:0]  FULL_C  = CNT_W'(FIFO_DEPTH);

   if (TX_LOW_ALT >= FIFO_DEPTH || RX_HIGH_NRM >= FIFO_DEPTH) begin : g_bad_depth
      $error("hdlc_isr: FIFO_DEPTH too small for thresholds");
   end
   if (TX_LOW_NRM == 0 || TX_LOW_ALT == 0) begin : g_bad_tx
      $error("hdlc_isr: Tx thresholds must be nonzero");
   end
   if (ISR_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("hdlc_isr: ISR_ADDR does not fit ADDR_W");
   end

   logic rd_now, rd_q, rd_end;
   logic tx_low_ev, rx_high_ev, abort_ev, under_ev, ovfl_ev;
   isr_t ev, stat_q, stat_nxt;

   assign rd_now = rd_stb_i && (rd_addr_i == MY_ADDR);
   assign rd_end = rd_q && !rd_now;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q <= 1'b0;
      else         rd_q <= rd_now;
   end

   isr_level_cross #(
      .CNT_W(CNT_W), .NRM_FROM(TX_LOW_NRM), .NRM_TO(TX_LOW_NRM - 1),
      .ALT_FROM(TX_LOW_ALT), .ALT_TO(TX_LOW_ALT - 1)
   ) u_tx_low (
      .clk_i(clk_i), .rst_ni(rst_ni), .alt_i(fltx_i),
      .count_i(tx_count_i), .cross_o(tx_low_ev)
   );

   isr_level_cross #(
      .CNT_W(CNT_W), .NRM_FROM(RX_HIGH_NRM), .NRM_TO(RX_HIGH_NRM + 1),
      .ALT_FROM(RX_HIGH_ALT), .ALT_TO(RX_HIGH_ALT + 1)
   ) u_rx_high (
      .clk_i(clk_i), .rst_ni(rst_ni), .alt_i(flrx_i),
      .count_i(rx_count_i), .cross_o(rx_high_ev)
   );

   isr_abort_qual #(.MIN_BITS(ABORT_MIN)) u_abort (
      .clk_i(clk_i), .rst_ni(rst_ni), .flag_i(rx_flag_i),
      .bit_i(rx_bit_i), .abort_i(rx_abort_i), .valid_o(abort_ev)
   );

   assign under_ev = tx_rd_i && (tx_count_i == '0) && !tx_last_tag_i;
   assign ovfl_ev  = rx_wr_i && (rx_count_i == FULL_C);

   always_comb begin
      ev          = '0;
      ev[B_GA]    = ga_det_i;
      ev[B_EOPW]  = eop_wr_i;
      ev[B_TXEND] = tx_done_i;
      ev[B_EOPR]  = eop_rd_i;
      ev[B_TXLOW] = tx_low_ev;
      ev[B_ABUND] = intsel_i ? under_ev : abort_ev;
      ev[B_RXHI]  = rx_high_ev;
      ev[B_RXOV]  = ovfl_ev;
   end

   for (genvar i = 0; i < ISR_W; i++) begin : g_bit
      isr_capture_bit u_cap (
         .clk_i(clk_i), .rst_ni(rst_ni), .rd_now_i(rd_now),
         .rd_end_i(rd_end), .ev_i(ev[i]),
         .stat_o(stat_q[i]), .stat_nxt_o(stat_nxt[i])
      );
   end

   assign rd_data_o = rd_now ? stat_q : '0;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= |(stat_nxt & irq_en_i);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |(stat_q & irq_en_i);
   end
endmodule

// File: rtl/hdlc_isr_chk.sv
module hdlc_isr_chk #(
   parameter int unsigned CNT_W      = 5,
   parameter int unsigned FIFO_DEPTH = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             rd_now,
   input logic             rd_q,
   input logic [7:0]       stat_q,
   input logic [7:0]       irq_en_i,
   input logic             irq_o,
   input logic [7:0]       rd_data_o,
   input logic             rx_wr_i,
   input logic [CNT_W-1:0] rx_count_i
);
   p_frozen_in_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_now && rd_q) |-> $stable(stat_q));

   p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(stat_q) & ~stat_q) != 8'h00) |-> ($past(rd_q) && !$past(rd_now)));

   p_irq_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == |(stat_q & $past(irq_en_i)));

   p_no_data_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_now |-> rd_data_o == 8'h00);

   p_ovfl_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_wr_i && rx_count_i == CNT_W'(FIFO_DEPTH) && !rd_now) |=> stat_q[0]);
endmodule

bind hdlc_isr hdlc_isr_chk #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .rd_now(rd_now), .rd_q(rd_q),
   .stat_q(stat_q), .irq_en_i(irq_en_i), .irq_o(irq_o),
   .rd_data_o(rd_data_o), .rx_wr_i(rx_wr_i), .rx_count_i(rx_count_i)
);

// File: tb/hdlc_isr_test.sv
module hdlc_isr_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ga, eopw, txd, eopr, rxwr, txrd, ttag, rflag, rbit, rab;
   logic fltx, flrx, intsel, stb;
   logic [4:0] rxc, txc;
   logic [7:0] en, rdat;
   logic [3:0] addr;
   logic irq;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hdlc_isr uut (
      .clk_i(clk), .rst_ni(rst_n), .ga_det_i(ga), .eop_wr_i(eopw),
      .tx_done_i(txd), .eop_rd_i(eopr), .rx_wr_i(rxwr), .rx_count_i(rxc),
      .tx_count_i(txc), .tx_rd_i(txrd), .tx_last_tag_i(ttag),
      .rx_flag_i(rflag), .rx_bit_i(rbit), .rx_abort_i(rab), .fltx_i(fltx),
      .flrx_i(flrx), .intsel_i(intsel), .irq_en_i(en), .rd_stb_i(stb),
      .rd_addr_i(addr), .rd_data_o(rdat), .irq_o(irq)
   );

   function automatic logic exp_irq(input logic [7:0] s, input logic [7:0] m);
      return |(s & m);
   endfunction

   function automatic logic [7:0] pulse_bits(input logic [7:0] r);
      return r & 8'hF1;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive_pulses(input logic [7:0] m);
      ga = m[7]; eopw = m[6]; txd = m[5]; eopr = m[4];
      rxwr = m[0]; if (m[0]) rxc = 5'd16;
   endtask

   task automatic clear_pulses();
      ga = 0; eopw = 0; txd = 0; eopr = 0; rxwr = 0; txrd = 0; rab = 0; rflag = 0;
   endtask

   task automatic fire(input logic [7:0] m);
      @(negedge clk); drive_pulses(m);
      @(negedge clk); clear_pulses(); rxc = 5'd0;
   endtask

   task automatic bus_read(input logic [7:0] mid, output logic [7:0] d);
      @(negedge clk); addr = 4'd7; stb = 1; #1 d = rdat;
      @(negedge clk); drive_pulses(mid);
      @(negedge clk); clear_pulses(); rxc = 5'd0; stb = 0;
      @(negedge clk);
   endtask

   task automatic set_count(input bit tx, input int v);
      @(negedge clk); if (tx) txc = 5'(v); else rxc = 5'(v);
   endtask

   task automatic abort_after(input int nbits);
      @(negedge clk); rflag = 1;
      @(negedge clk); rflag = 0; rbit = 1;
      repeat (nbits) @(negedge clk);
      rbit = 0; rab = 1;
      @(negedge clk); rab = 0;
   endtask

   initial begin
      #400000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d, m, e;
      void'($urandom(32'h5eed));
      clear_pulses(); rbit = 0; ttag = 0; fltx = 0; flrx = 0; intsel = 0;
      stb = 0; addr = 0; rxc = 0; txc = 0; en = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 irq", {7'd0, irq}, 8'h00);
      bus_read(8'h00, d); check("R1 status", d, 8'h00);

      // R2/R3/R4 random event patterns
      for (int i = 0; i < 40; i++) begin
         m  = pulse_bits(8'($urandom));
         en = 8'($urandom);
         fire(m);
         check("R4 irq", {7'd0, irq}, {7'd0, exp_irq(m, en)});
         bus_read(8'h00, d); check("R2 bits", d, m);
         check("R4 irq after read", {7'd0, irq}, 8'h00);
         bus_read(8'h00, d); check("R3 cleared", d, 8'h00);
      end
      en = 8'hFF;

      // R5 Tx threshold
      set_count(1, 6); set_count(1, 5); set_count(1, 4); set_count(1, 5);
      @(negedge clk); bus_read(8'h00, d); check("R5 5to4", d, 8'h08);
      set_count(1, 3); set_count(1, 4); set_count(1, 5); set_count(1, 4);
      set_count(1, 0); @(negedge clk);
      bus_read(8'h00, d); check("R5 repeat 5to4", d, 8'h08);
      set_count(1, 5); set_count(1, 6); set_count(1, 5); set_count(1, 0);
      bus_read(8'h00, d); check("R5 upward none", d, 8'h00);
      fltx = 1;
      set_count(1, 5); set_count(1, 4); set_count(1, 0);
      bus_read(8'h00, d); check("R5 alt ignores 5to4", d, 8'h00);
      set_count(1, 15); set_count(1, 14); set_count(1, 0);
      bus_read(8'h00, d); check("R5 alt 15to14", d, 8'h08);
      fltx = 0;

      // R6 Rx threshold
      set_count(0, 14); set_count(0, 15); set_count(0, 0);
      bus_read(8'h00, d); check("R6 14to15", d, 8'h02);
      set_count(0, 4); set_count(0, 5); set_count(0, 0);
      bus_read(8'h00, d); check("R6 4to5 normal none", d, 8'h00);
      flrx = 1;
      set_count(0, 4); set_count(0, 5); set_count(0, 0);
      bus_read(8'h00, d); check("R6 alt 4to5", d, 8'h02);
      set_count(0, 14); set_count(0, 15); set_count(0, 0);
      bus_read(8'h00, d); check("R6 alt ignores 14to15", d, 8'h00);
      flrx = 0;

      // R7 abort qualification
      abort_after(25); bus_read(8'h00, d); check("R7 short abort", d, 8'h00);
      abort_after(26); bus_read(8'h00, d); check("R7 long abort", d, 8'h04);
      abort_after(40); bus_read(8'h00, d); check("R7 longer abort", d, 8'h04);

      // R8 underrun select
      intsel = 1;
      @(negedge clk); txrd = 1; ttag = 0;
      @(negedge clk); txrd = 0;
      bus_read(8'h00, d); check("R8 underrun", d, 8'h04);
      @(negedge clk); txrd = 1; ttag = 1;
      @(negedge clk); txrd = 0; ttag = 0;
      bus_read(8'h00, d); check("R8 tagged none", d, 8'h00);
      abort_after(30); bus_read(8'h00, d); check("R8 abort ignored", d, 8'h00);
      intsel = 0;

      // R9 deferral and R10 drop
      for (int i = 0; i < 8; i++) begin
         m = pulse_bits(8'($urandom));
         e = pulse_bits(8'($urandom));
         fire(m);
         bus_read(e, d); check("R9 read unaffected", d, m);
         bus_read(8'h00, d); check("R10 deferred/dropped", d, e & ~m);
      end
      fire(8'h40);
      bus_read(8'h40, d); check("R10 already set", d, 8'h40);
      bus_read(8'h00, d); check("R10 dropped", d, 8'h00);

      // R11 other address
      fire(8'h81);
      @(negedge clk); addr = 4'd3; stb = 1; #1 d = rdat;
      check("R11 data zero", d, 8'h00);
      @(negedge clk); stb = 0;
      @(negedge clk);
      check("R11 irq kept", {7'd0, irq}, 8'h01);
      bus_read(8'h00, d); check("R11 not cleared", d, 8'h81);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule